// File: doc/BRIEF.md
# Timer with Shared Prescaler / Watchdog Postscaler

This block holds an 8-bit timer/counter and a watchdog, and one hidden 8-bit divider that serves only one of them at a time. An option register picks what the timer counts. It can count ticks of the internal instruction clock, or edges on an external pin, and for the pin it picks rising or falling edges. The same register decides where the divider sits. It either slows the timer down as a prescaler, or it stretches the watchdog period as a postscaler. It also sets the division ratio.

Software reaches the timer and option registers over a simple single-cycle bus. When the timer passes from 0xFF to 0x00, an overflow flag is raised and stays set until it is cleared. The watchdog counts ticks from an external watchdog oscillator and emits a one-cycle timeout pulse for the reset logic. A clear strobe restarts the watchdog. Software can never see the divider. It is cleared by a write to the timer when the timer owns it, by a watchdog clear when the watchdog owns it, and whenever its owner changes.

Top module: `tmr_wdt_div`

## Requirements
- R1: After reset the timer reads 0x00, the option register reads 0xFF, and the overflow flag and the timeout output are 0. Because the option register resets to 0xFF, the divider starts out owned by the watchdog.
- R2: The bus selects a register with bus_addr, where 0 is the timer and 1 is the option register. A write with bus_we takes effect at the next clock edge, and bus_rdata shows the selected register combinationally. The timer keeps its value in every cycle with no write and no count event.
- R3: When option bit 5 is 0, the timer's source event is inst_tick. When it is 1, the source event is an edge on ext_pin, taken after a two-flop synchronizer, and counted 3 clocks after the pin changes. With bit 5 at 1, option bit 4 selects the edge: 0 counts rising edges and 1 counts falling edges.
- R4: When option bit 3 is 0, the divider belongs to the timer. The timer then advances once per 2^(PS+1) source events, where PS is option bits 2:0, so the ratio runs from 1:2 to 1:256.
- R5: The timer wraps from 0xFF to 0x00 and sets ovf_flag in that same edge. The flag stays set until flag_clr is asserted, and a set in the same cycle as flag_clr wins.
- R6: A timer write in the same cycle as a count event loads the written value, and the event is lost. When option bit 3 is 0, a timer write also clears the divider.
- R7: The watchdog base period is 2^WDT_W wdt_tick pulses. When option bit 3 is 1, a timeout occurs after 2^PS base periods. When bit 3 is 0, a timeout occurs after each base period. wdt_timeout is a one-cycle pulse in the clock after the expiring tick.
- R8: wdt_clr clears the watchdog base counter. When option bit 3 is 1 it also clears the divider. No timeout pulse follows a clear cycle.
- R9: Any option write that changes bit 3 clears the divider, so no partial count carries over to the new owner.
- R10: When option bit 3 is 1, the timer advances on every source event (ratio 1:1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_tick | input | 1 | Instruction-clock enable, one pulse per instruction cycle |
| ext_pin | input | 1 | External count pin (asynchronous) |
| wdt_tick | input | 1 | One pulse per watchdog oscillator period |
| wdt_clr | input | 1 | Watchdog clear strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 timer, 1 option |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
Two pairs of functions can land in one clock. A software write to the timer can meet a count event, possibly the one that would have overflowed the timer. A watchdog clear can meet the tick that would have expired the watchdog. The bench sets these up directly: it writes the timer while it holds 0xFF and inst_tick is high, and it raises wdt_clr on the last tick of a base period. Random stimulus also makes both collisions happen many times over. A cycle-level reference model inside the bench judges every cycle. It expects the written value, no flag, and no timeout pulse after such collisions.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned PS_W   = 3;

  typedef struct packed {
    logic            pull_en;
    logic            irq_edge;
    logic            src_pin;
    logic            pin_fall;
    logic            div_to_wdt;
    logic [PS_W-1:0] ratio;
  } opt_t;

  localparam logic [DATA_W-1:0] OPT_RST = 8'hFF;

  // Low-bit mask of the divider that must be all ones for an output pulse.
  function automatic logic [DATA_W-1:0] tap_mask(input logic [PS_W-1:0] ps,
                                                  input logic to_wdt);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) begin
      m[i] = to_wdt ? (i < int'(ps)) : (i <= int'(ps));
    end
    return m;
  endfunction
endpackage

// File: rtl/tmr_edge_src.sv
module tmr_edge_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pin,
  input  logic inst_tick,
  input  logic src_pin,
  input  logic pin_fall,
  output logic src_ev
);
  localparam int unsigned LAST = SYNC_STAGES;

  logic [LAST:0] sh_q, sh_d;
  logic          rise, fall;

  always_comb begin
    sh_d = {sh_q[LAST-1:0], ext_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise   = sh_q[LAST-1] & ~sh_q[LAST];
  assign fall   = ~sh_q[LAST-1] & sh_q[LAST];
  assign src_ev = src_pin ? (pin_fall ? fall : rise) : inst_tick;
endmodule

// File: rtl/tmr_shared_div.sv
module tmr_shared_div
  import tmr_wdt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ev,
  input  logic            to_wdt,
  input  logic [PS_W-1:0] ratio,
  output logic            tap
);
  logic [DATA_W-1:0] div_q, div_d, mask;

  assign mask = tap_mask(ratio, to_wdt);
  assign tap  = ((div_q & mask) == mask);

  always_comb begin
    div_d = div_q;
    if (clr)     div_d = '0;
    else if (ev) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_wdt_base.sv
module tmr_wdt_base #(
  parameter int unsigned WDT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_tick,
  input  logic wdt_clr,
  output logic base_wrap
);
  localparam logic [WDT_W-1:0] TOP = '1;

  logic [WDT_W-1:0] cnt_q, cnt_d;

  assign base_wrap = wdt_tick & ~wdt_clr & (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (wdt_clr)       cnt_d = '0;
    else if (wdt_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_wdt_div.sv
module tmr_wdt_div
  import tmr_wdt_pkg::*;
#(
  parameter int unsigned WDT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_tick,
  input  logic              ext_pin,
  input  logic              wdt_tick,
  input  logic              wdt_clr,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flag_clr,
  output logic              ovf_flag,
  output logic              wdt_timeout
);
  localparam logic [DATA_W-1:0] TMR_TOP = '1;

  opt_t              opt_q, opt_d;
  logic [DATA_W-1:0] tmr_q, tmr_d;
  logic              flag_d, to_d;
  logic              tmr_we, opt_we, src_ev, base_wrap, tap, div_clr, div_ev;
  logic              tmr_inc, expire;

  assign tmr_we = bus_we & ~bus_addr;
  assign opt_we = bus_we &  bus_addr;

  tmr_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .inst_tick(inst_tick),
    .src_pin(opt_q.src_pin), .pin_fall(opt_q.pin_fall), .src_ev(src_ev)
  );

  tmr_wdt_base #(.WDT_W(WDT_W)) u_base (
    .clk(clk), .rst_n(rst_n), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr),
    .base_wrap(base_wrap)
  );

  assign div_ev  = opt_q.div_to_wdt ? base_wrap : src_ev;
  assign div_clr = (opt_we & (bus_wdata[3] != opt_q.div_to_wdt))
                 | (~opt_q.div_to_wdt & tmr_we)
                 | ( opt_q.div_to_wdt & wdt_clr);

  tmr_shared_div u_div (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .ev(div_ev),
    .to_wdt(opt_q.div_to_wdt), .ratio(opt_q.ratio), .tap(tap)
  );

  assign tmr_inc = ~tmr_we & src_ev & (opt_q.div_to_wdt | tap);
  assign expire  = base_wrap & (~opt_q.div_to_wdt | tap);

  always_comb begin
    tmr_d  = tmr_q;
    opt_d  = opt_q;
    flag_d = ovf_flag;
    to_d   = expire;
    if (tmr_we)       tmr_d = bus_wdata;
    else if (tmr_inc) tmr_d = tmr_q + 1'b1;
    if (opt_we)       opt_d = opt_t'(bus_wdata);
    if (tmr_inc && tmr_q == TMR_TOP) flag_d = 1'b1;
    else if (flag_clr)               flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q       <= '0;
      opt_q       <= opt_t'(OPT_RST);
      ovf_flag    <= 1'b0;
      wdt_timeout <= 1'b0;
    end else begin
      tmr_q       <= tmr_d;
      opt_q       <= opt_d;
      ovf_flag    <= flag_d;
      wdt_timeout <= to_d;
    end
  end

  assign bus_rdata = bus_addr ? DATA_W'(opt_q) : tmr_q;
endmodule

// File: rtl/tmr_wdt_chk.sv
module tmr_wdt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] tmr_q,
  input logic       tmr_inc,
  input logic       src_ev,
  input logic       div_to_wdt,
  input logic       ovf_flag,
  input logic       wdt_clr,
  input logic       wdt_timeout
);
  p_tmr_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> (tmr_q == $past(bus_wdata)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_we && !tmr_inc) |=> $stable(tmr_q));

  p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_inc && tmr_q == 8'hFF) |=> (ovf_flag && tmr_q == 8'h00));

  p_clr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_timeout);

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);

  p_one_to_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (div_to_wdt && src_ev && !tmr_we) |-> tmr_inc);
endmodule

bind tmr_wdt_div tmr_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_we(tmr_we), .bus_wdata(bus_wdata),
  .tmr_q(tmr_q), .tmr_inc(tmr_inc), .src_ev(src_ev),
  .div_to_wdt(opt_q.div_to_wdt), .ovf_flag(ovf_flag), .wdt_clr(wdt_clr),
  .wdt_timeout(wdt_timeout)
);

// File: tb/tmr_wdt_div_tb.sv
module tmr_wdt_div_tb;
  localparam int WDT_W = 4;
  localparam int WDT_TOP = (1 << WDT_W) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inst_tick = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0, wdt_clr = 1'b0;
  logic       bus_we = 1'b0, bus_addr = 1'b0, flag_clr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ovf_flag, wdt_timeout;

  int vectors = 0, errors = 0, to_seen = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  tmr_wdt_div #(.WDT_W(WDT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .inst_tick(inst_tick), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag), .wdt_timeout(wdt_timeout)
  );

  // Reference model, written from the requirements
  logic [7:0] m_tmr, m_opt, m_div;
  logic [WDT_W-1:0] m_wdt;
  logic m_flag, m_to;
  logic [2:0] m_s;

  function automatic bit tap_of(input logic [7:0] d, input logic [7:0] opt);
    int span = opt[3] ? (1 << opt[2:0]) : (2 << opt[2:0]);
    return (int'(d) % span) == span - 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmr <= 8'h00; m_opt <= 8'hFF; m_div <= 8'h00; m_wdt <= '0;
      m_flag <= 1'b0; m_to <= 1'b0; m_s <= 3'b000;
    end else begin
      automatic bit src  = m_opt[5] ? (m_opt[4] ? (m_s[2] & ~m_s[1]) : (m_s[1] & ~m_s[2]))
                                    : inst_tick;
      automatic bit psa  = m_opt[3];
      automatic bit tw   = bus_we && !bus_addr;
      automatic bit ow   = bus_we && bus_addr;
      automatic bit wrap = wdt_tick && !wdt_clr && (int'(m_wdt) == WDT_TOP);
      automatic bit tp   = tap_of(m_div, m_opt);
      automatic bit inc  = !tw && src && (psa || tp);
      automatic bit dclr = (ow && bus_wdata[3] != psa) || (!psa && tw) || (psa && wdt_clr);
      m_s <= {m_s[1:0], ext_pin};
      m_to <= wrap && (!psa || tp);
      if (wdt_clr) m_wdt <= '0; else if (wdt_tick) m_wdt <= m_wdt + 1'b1;
      if (dclr) m_div <= 8'h00; else if (psa ? wrap : src) m_div <= m_div + 1'b1;
      if (tw) m_tmr <= bus_wdata; else if (inc) m_tmr <= m_tmr + 1'b1;
      if (ow) m_opt <= bus_wdata;
      if (inc && m_tmr == 8'hFF) m_flag <= 1'b1; else if (flag_clr) m_flag <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string t, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  // One clock: inputs already set after a falling edge; compare at the next falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (wdt_timeout) to_seen++;
    check(bus_rdata === (bus_addr ? m_opt : m_tmr), tag, "rdata", bus_rdata,
          bus_addr ? m_opt : m_tmr);
    check(ovf_flag === m_flag, tag, "flag", ovf_flag, m_flag);
    check(wdt_timeout === m_to, tag, "timeout", wdt_timeout, m_to);
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_we = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin inst_tick = 1'b1; cyc(); end
    inst_tick = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset values
    check(bus_rdata === 8'h00 && ovf_flag === 1'b0 && wdt_timeout === 1'b0, "R1",
          "reset timer/flag/timeout", bus_rdata, 0);
    bus_addr = 1'b1; #1;
    check(bus_rdata === 8'hFF, "R1", "reset option", bus_rdata, 8'hFF);
    bus_addr = 1'b0;
    rst_n = 1'b1;
    cyc();

    tag = "R2";
    wr(1'b1, 8'h08); wr(1'b0, 8'h5A);
    check(bus_rdata === 8'h5A, "R2", "timer readback", bus_rdata, 8'h5A);
    cyc(); cyc();
    check(bus_rdata === 8'h5A, "R2", "timer holds", bus_rdata, 8'h5A);

    tag = "R10";
    ticks(5);
    check(bus_rdata === 8'h5F, "R10", "1:1 count", bus_rdata, 8'h5F);

    tag = "R4";
    wr(1'b1, 8'h01); wr(1'b0, 8'h00);
    ticks(12);
    check(bus_rdata === 8'h03, "R4", "1:4 count", bus_rdata, 8'h03);
    wr(1'b1, 8'h07); wr(1'b0, 8'h00);
    ticks(256);
    check(bus_rdata === 8'h01, "R4", "1:256 count", bus_rdata, 8'h01);

    tag = "R5";
    wr(1'b1, 8'h08); wr(1'b0, 8'hFE);
    ticks(2);
    check(bus_rdata === 8'h00 && ovf_flag === 1'b1, "R5", "wrap sets flag", ovf_flag, 1);
    cyc();
    check(ovf_flag === 1'b1, "R5", "flag sticky", ovf_flag, 1);
    flag_clr = 1'b1; cyc(); flag_clr = 1'b0;
    check(ovf_flag === 1'b0, "R5", "flag cleared", ovf_flag, 0);

    tag = "R6";
    wr(1'b0, 8'hFF);
    inst_tick = 1'b1; wr(1'b0, 8'h33); inst_tick = 1'b0;
    check(bus_rdata === 8'h33 && ovf_flag === 1'b0, "R6", "write wins", bus_rdata, 8'h33);

    tag = "R9";
    wr(1'b1, 8'h01); ticks(3); wr(1'b1, 8'h09); wr(1'b1, 8'h01); wr(1'b0, 8'h00);
    ticks(3);
    check(bus_rdata === 8'h00, "R9", "divider cleared", bus_rdata, 8'h00);

    tag = "R3";
    wr(1'b1, 8'h28); wr(1'b0, 8'h00);
    for (int i = 0; i < 4; i++) begin ext_pin = ~ext_pin; cyc(); cyc(); cyc(); end
    check(bus_rdata === 8'h02, "R3", "rising edges", bus_rdata, 8'h02);
    wr(1'b1, 8'h38);
    ext_pin = 1'b1; cyc(); cyc(); cyc(); cyc();
    ext_pin = 1'b0; cyc(); cyc();
    check(bus_rdata === 8'h02, "R3", "falling not yet", bus_rdata, 8'h02);
    cyc();
    check(bus_rdata === 8'h03, "R3", "falling edge 3 clocks", bus_rdata, 8'h03);

    tag = "R7";
    wr(1'b1, 8'h0A); to_seen = 0;
    wdt_clr = 1'b1; cyc(); wdt_clr = 1'b0;
    for (int i = 0; i < 4 * (WDT_TOP + 1); i++) begin wdt_tick = 1'b1; cyc(); end
    wdt_tick = 1'b0;
    check(to_seen === 1, "R7", "timeouts at 1:4", to_seen, 1);

    tag = "R8";
    wr(1'b1, 8'h00);
    wdt_clr = 1'b1; cyc(); wdt_clr = 1'b0;
    for (int i = 0; i < WDT_TOP; i++) begin wdt_tick = 1'b1; cyc(); end
    wdt_clr = 1'b1; cyc(); wdt_clr = 1'b0; wdt_tick = 1'b0;
    check(wdt_timeout === 1'b0, "R8", "clear on last tick", wdt_timeout, 0);

    tag = "R2 R3 R4 R5 R6 R7 R8 R9 R10";
    for (int i = 0; i < 20000; i++) begin
      automatic int r = $urandom_range(0, 99);
      inst_tick = $urandom_range(0, 3) != 0;
      wdt_tick  = $urandom_range(0, 1);
      wdt_clr   = $urandom_range(0, 60) == 0;
      flag_clr  = $urandom_range(0, 30) == 0;
      if ($urandom_range(0, 4) == 0) ext_pin = ~ext_pin;
      bus_we = r < 6;
      bus_addr = (r < 2) || (r >= 80);
      bus_wdata = (r < 2) ? ($urandom_range(0, 255) & 8'h3F) : 8'($urandom_range(250, 255));
      if (r >= 2 && r < 6 && $urandom_range(0, 1)) bus_wdata = 8'($urandom);
      cyc();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule